// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block expands one scalar-encoded operation into a run of per-element scalar micro-operations. It acts as a loop in hardware. Each incoming operation carries three tags. The tags say which of the destination and the two sources are to be treated as vectors. While the loop runs, the sequencer holds the program counter. It walks an element index upward and sends out one micro-operation per enabled element. The register numbers of the vector-tagged operands advance with the element index. The register numbers of the scalar operands stay where they are.

A single opcode therefore covers the scalar-scalar, scalar-vector and vector-vector forms. A predicate word is read from an integer register at the moment the operation is accepted, and it gates each element. Elements whose predicate bit is clear are skipped and produce no micro-operation, so their destination is never written. Micro-operations leave through a valid/ready handshake toward an issue queue. When the last element has been dealt with, a one-cycle done pulse is raised and the program counter is released.

Top module: `vec_elem_seq`

## Requirements
- R1: `op_ready` is high exactly when no loop is running. An operation is accepted on a cycle with `op_valid` and `op_ready` both high. `hold_pc` is high from the cycle after the accept of an operation with a non-zero effective length until its loop ends.
- R2: Elements are visited in increasing index order, starting at 0. Each micro-operation reports its index on `uop_elem` and carries the accepted opcode on `uop_code`.
- R3: Element i produces a micro-operation only when bit i of `pred_rdata` is 1. `pred_rdata` is sampled in the accept cycle, and `pred_raddr` presents `op_pred_reg` as the read address during that cycle. An element whose bit is 0 emits nothing, so its destination is left unwritten.
- R4: For an operand whose vector tag is set, the register number sent with element i is the accepted base number plus i, modulo 2^REG_W. The count of i includes skipped elements.
- R5: For an operand whose vector tag is clear, every micro-operation carries the accepted base register number unchanged.
- R6: When none of the three tags is set and VL is non-zero, only element 0 is considered, so at most one micro-operation is sent. Predicate bit 0 gates it.
- R7: When VL is 0, `done` is high in the cycle after the accept. No micro-operation is sent, and `hold_pc` stays low.
- R8: While `uop_valid` is high and `uop_ready` is low, the micro-operation stays valid with all of its fields unchanged. No element is dropped or sent twice.
- R9: `done` is a single-cycle pulse. It comes in the cycle after the last element is accepted or skipped, and in that same cycle `hold_pc` is low.
- R10: A VL value above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer idle, can accept |
| op_code | input | OPC_W | Scalar opcode |
| op_rd | input | REG_W | Destination base register |
| op_rs1 | input | REG_W | Source 1 base register |
| op_rs2 | input | REG_W | Source 2 base register |
| op_vec_rd | input | 1 | Destination is vector-tagged |
| op_vec_rs1 | input | 1 | Source 1 is vector-tagged |
| op_vec_rs2 | input | 1 | Source 2 is vector-tagged |
| op_pred_reg | input | REG_W | Integer register holding the predicate |
| op_vl | input | VL_W | Requested vector length |
| pred_raddr | output | REG_W | Predicate register read address |
| pred_rdata | input | MAX_VL | Predicate value read back |
| uop_valid | output | 1 | Micro-operation valid |
| uop_ready | input | 1 | Issue queue accepts |
| uop_code | output | OPC_W | Micro-operation opcode |
| uop_rd | output | REG_W | Element destination register |
| uop_rs1 | output | REG_W | Element source 1 register |
| uop_rs2 | output | REG_W | Element source 2 register |
| uop_elem | output | IDX_W | Element index |
| hold_pc | output | 1 | Program counter held |
| done | output | 1 | Loop finished pulse |

## Verification
The bench builds the block with MAX_VL=16, REG_W=5 and OPC_W=6. With these values a base register near the top of the 32-entry file wraps round within one loop, and a requested length of 20 exercises the clamp to 16. A full-length loop fits in a few dozen cycles, which leaves room to run it under a pseudo-random ready pattern that stalls the queue many times. Predicate words of 16 bits allow all-ones, all-zero and sparse patterns.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  // Effective element count: clamp to the maximum, collapse to one when
  // no operand carries a vector tag.
  function automatic int unsigned loop_len(input int unsigned req_vl,
                                           input int unsigned max_vl,
                                           input logic        any_vec);
    int unsigned clamped;
    clamped = (req_vl > max_vl) ? max_vl : req_vl;
    if (!any_vec && clamped != 0) clamped = 1;
    return clamped;
  endfunction

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  start_len,
  input  logic             step,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  logic             busy_q, busy_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [VL_W-1:0]  len_q, len_n;
  logic             done_q, done_n;
  logic             is_last;
  logic             en;

  assign is_last = ({1'b0, idx_q} + VL_W'(1)) == len_q;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    len_n  = len_q;
    done_n = 1'b0;
    if (start) begin
      if (start_len == '0) begin
        done_n = 1'b1;
      end else begin
        busy_n = 1'b1;
        idx_n  = '0;
        len_n  = start_len;
      end
    end else if (busy_q && step) begin
      idx_n = idx_q + IDX_W'(1);
      if (is_last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  assign en = start | (busy_q & step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
      if (en) begin
        busy_q <= busy_n;
        idx_q  <= idx_n;
        len_q  <= len_n;
      end
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = done_q;

endmodule

// File: rtl/vseq_opnd.sv
module vseq_opnd #(
  parameter int REG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] base_in,
  input  logic             vec_in,
  input  logic             step,
  output logic [REG_W-1:0] reg_num
);

  logic [REG_W-1:0] base_q;
  logic [REG_W-1:0] off_q, off_n;
  logic             vec_q;
  logic             off_en;

  always_comb begin
    off_n = off_q;
    if (load)      off_n = '0;
    else if (step) off_n = off_q + REG_W'(1);
  end

  assign off_en = load | (step & vec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= 1'b0;
    end else if (load) begin
      base_q <= base_in;
      vec_q  <= vec_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_n;
  end

  assign reg_num = base_q + off_q;

endmodule

// File: rtl/vseq_pred.sv
module vseq_pred #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic [IDX_W-1:0]  idx,
  output logic              enabled
);

  logic [MAX_VL-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= mask_in;
  end

  assign enabled = mask_q[idx];

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int MAX_VL = 64,
  parameter int REG_W  = 7,
  parameter int OPC_W  = 8,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int N_OPND = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [REG_W-1:0]  op_rd,
  input  logic [REG_W-1:0]  op_rs1,
  input  logic [REG_W-1:0]  op_rs2,
  input  logic              op_vec_rd,
  input  logic              op_vec_rs1,
  input  logic              op_vec_rs2,
  input  logic [REG_W-1:0]  op_pred_reg,
  input  logic [VL_W-1:0]   op_vl,
  output logic [REG_W-1:0]  pred_raddr,
  input  logic [MAX_VL-1:0] pred_rdata,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [OPC_W-1:0]  uop_code,
  output logic [REG_W-1:0]  uop_rd,
  output logic [REG_W-1:0]  uop_rs1,
  output logic [REG_W-1:0]  uop_rs2,
  output logic [IDX_W-1:0]  uop_elem,
  output logic              hold_pc,
  output logic              done
);

  import vseq_pkg::*;

  logic             busy;
  logic             accept;
  logic             step;
  logic             elem_on;
  logic             any_vec;
  logic [VL_W-1:0]  eff_len;
  logic [IDX_W-1:0] idx;
  logic [OPC_W-1:0] code_q;

  logic [REG_W-1:0] opnd_base [N_OPND];
  logic             opnd_vec  [N_OPND];
  logic [REG_W-1:0] opnd_num  [N_OPND];

  assign op_ready   = ~busy;
  assign accept     = op_valid & op_ready;
  assign pred_raddr = op_pred_reg;
  assign any_vec    = op_vec_rd | op_vec_rs1 | op_vec_rs2;
  assign eff_len    = VL_W'(loop_len(int'(op_vl), MAX_VL, any_vec));

  // A masked-off element retires without waiting for the queue.
  assign step = busy & (~elem_on | uop_ready);

  vseq_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_len (eff_len),
    .step      (step),
    .busy      (busy),
    .idx       (idx),
    .done      (done)
  );

  vseq_pred #(.MAX_VL(MAX_VL)) u_pred (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .mask_in (pred_rdata),
    .idx     (idx),
    .enabled (elem_on)
  );

  assign opnd_base[0] = op_rd;
  assign opnd_base[1] = op_rs1;
  assign opnd_base[2] = op_rs2;
  assign opnd_vec[0]  = op_vec_rd;
  assign opnd_vec[1]  = op_vec_rs1;
  assign opnd_vec[2]  = op_vec_rs2;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    vseq_opnd #(.REG_W(REG_W)) u_opnd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .base_in (opnd_base[g]),
      .vec_in  (opnd_vec[g]),
      .step    (step),
      .reg_num (opnd_num[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (accept) code_q <= op_code;
  end

  assign uop_valid = busy & elem_on;
  assign uop_code  = code_q;
  assign uop_rd    = opnd_num[0];
  assign uop_rs1   = opnd_num[1];
  assign uop_rs2   = opnd_num[2];
  assign uop_elem  = idx;
  assign hold_pc   = busy;

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int MAX_VL = 64,
  parameter int REG_W  = 7,
  parameter int OPC_W  = 8,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [VL_W-1:0]   op_vl,
  input logic              uop_valid,
  input logic              uop_ready,
  input logic [OPC_W-1:0]  uop_code,
  input logic [REG_W-1:0]  uop_rd,
  input logic [REG_W-1:0]  uop_rs1,
  input logic [REG_W-1:0]  uop_rs2,
  input logic [IDX_W-1:0]  uop_elem,
  input logic              hold_pc,
  input logic              done
);

  assert_issue_in_loop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> hold_pc);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_rd) && $stable(uop_rs1)
      && $stable(uop_rs2) && $stable(uop_elem) && $stable(uop_code));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold_pc);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && op_vl == '0 |=> done && !hold_pc && !uop_valid);

endmodule

bind vec_elem_seq vseq_chk #(.MAX_VL(MAX_VL), .REG_W(REG_W), .OPC_W(OPC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_vl     (op_vl),
  .uop_valid (uop_valid),
  .uop_ready (uop_ready),
  .uop_code  (uop_code),
  .uop_rd    (uop_rd),
  .uop_rs1   (uop_rs1),
  .uop_rs2   (uop_rs2),
  .uop_elem  (uop_elem),
  .hold_pc   (hold_pc),
  .done      (done)
);

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;

  localparam int MAX_VL = 16;
  localparam int REG_W  = 5;
  localparam int OPC_W  = 6;
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int ITEM_W = OPC_W + 3 * REG_W + IDX_W;

  logic              clk;
  logic              rst_n;
  logic              op_valid;
  logic              op_ready;
  logic [OPC_W-1:0]  op_code;
  logic [REG_W-1:0]  op_rd, op_rs1, op_rs2, op_pred_reg;
  logic              op_vec_rd, op_vec_rs1, op_vec_rs2;
  logic [VL_W-1:0]   op_vl;
  logic [REG_W-1:0]  pred_raddr;
  logic [MAX_VL-1:0] pred_rdata;
  logic              uop_valid;
  logic              uop_ready;
  logic [OPC_W-1:0]  uop_code;
  logic [REG_W-1:0]  uop_rd, uop_rs1, uop_rs2;
  logic [IDX_W-1:0]  uop_elem;
  logic              hold_pc;
  logic              done;

  vec_elem_seq #(.MAX_VL(MAX_VL), .REG_W(REG_W), .OPC_W(OPC_W)) u_vec_elem_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2),
    .op_vec_rd(op_vec_rd), .op_vec_rs1(op_vec_rs1), .op_vec_rs2(op_vec_rs2),
    .op_pred_reg(op_pred_reg), .op_vl(op_vl), .pred_raddr(pred_raddr),
    .pred_rdata(pred_rdata), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_code(uop_code), .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2),
    .uop_elem(uop_elem), .hold_pc(hold_pc), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [ITEM_W-1:0] sb [$];
  logic [7:0] lf;
  logic       rmode;
  logic       stall_prev;
  logic [ITEM_W-1:0] prev_item;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    uop_ready <= rmode ? lf[0] : 1'b1;
  end

  // Monitor: compare every handshake with the scoreboard front.
  always @(negedge clk) begin
    logic [ITEM_W-1:0] got, exp;
    if (rst_n) begin
      got = {uop_code, uop_rd, uop_rs1, uop_rs2, uop_elem};
      if (stall_prev)
        check(uop_valid && got == prev_item, "R8", "stalled uop changed",
              longint'(got), longint'(prev_item));
      if (uop_valid && uop_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3", "unexpected uop", longint'(got), 0);
        end else begin
          exp = sb.pop_front();
          check(got == exp, "R2/R4/R5", "uop fields", longint'(got), longint'(exp));
        end
      end
      stall_prev = uop_valid && !uop_ready;
      prev_item  = got;
    end
  end

  // Driver: build expected uops from the requirements, then offer the op.
  task automatic run_op(input logic [OPC_W-1:0] opc, input logic [REG_W-1:0] rd,
                        input logic [REG_W-1:0] rs1, input logic [REG_W-1:0] rs2,
                        input logic vr, input logic v1, input logic v2,
                        input int vl, input logic [MAX_VL-1:0] pred, input string req);
    int eff;
    int wait_cyc;
    eff = (vl > MAX_VL) ? MAX_VL : vl;                 // R10
    if (!(vr | v1 | v2) && eff > 0) eff = 1;           // R6
    for (int i = 0; i < eff; i++) begin
      if (pred[i])                                     // R3
        sb.push_back({opc, REG_W'(rd + (vr ? i : 0)), REG_W'(rs1 + (v1 ? i : 0)),
                      REG_W'(rs2 + (v2 ? i : 0)), IDX_W'(i)});
    end
    @(negedge clk);
    check(op_ready, "R1", "ready when idle", op_ready, 1);
    op_valid = 1'b1; op_code = opc; op_rd = rd; op_rs1 = rs1; op_rs2 = rs2;
    op_vec_rd = vr; op_vec_rs1 = v1; op_vec_rs2 = v2;
    op_vl = VL_W'(vl); pred_rdata = pred; op_pred_reg = rd ^ 5'h11;
    #1;
    check(pred_raddr == (rd ^ 5'h11), "R3", "predicate read address",
          pred_raddr, rd ^ 5'h11);
    @(negedge clk);
    op_valid = 1'b0;
    if (eff == 0) begin
      check(done && !hold_pc, "R7", "zero length done", {done, hold_pc}, 2'b10);
    end else begin
      check(hold_pc && !op_ready, "R1", "pc held in loop", {hold_pc, op_ready}, 2'b10);
      wait_cyc = 0;
      while (!done && wait_cyc < 2000) begin
        @(negedge clk);
        wait_cyc++;
      end
      check(done && !hold_pc, {req, " R9"}, "done with pc released",
            {done, hold_pc}, 2'b10);
    end
    check(sb.size() == 0, {req, " R3"}, "uops left over", sb.size(), 0);
    @(negedge clk);
    check(!done && !hold_pc, "R9", "done single pulse", {done, hold_pc}, 0);
    sb.delete();
  endtask

  initial begin
    rst_n = 1'b0; rmode = 1'b0; lf = 8'h5a; stall_prev = 1'b0; prev_item = '0;
    op_valid = 1'b0; op_code = '0; op_rd = '0; op_rs1 = '0; op_rs2 = '0;
    op_vec_rd = 1'b0; op_vec_rs1 = 1'b0; op_vec_rs2 = 1'b0;
    op_pred_reg = '0; op_vl = '0; pred_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_ready && !uop_valid && !done && !hold_pc, "R1", "reset state",
          {op_ready, uop_valid, done, hold_pc}, 4'b1000);

    run_op(6'h01, 5'd2, 5'd8, 5'd14, 1, 1, 1, 5, 16'hffff, "R2 R4 vv");
    rmode = 1'b1;
    run_op(6'h02, 5'd4, 5'd9, 5'd20, 1, 0, 1, 8, 16'h00a5, "R3 R5 sv");
    run_op(6'h03, 5'd7, 5'd3, 5'd1, 0, 0, 0, 7, 16'h00ff, "R6 scalar");
    run_op(6'h04, 5'd7, 5'd3, 5'd1, 0, 0, 0, 7, 16'h00fe, "R6 scalar masked");
    run_op(6'h05, 5'd1, 5'd2, 5'd3, 1, 1, 1, 0, 16'hffff, "R7 zero");
    run_op(6'h06, 5'd28, 5'd30, 5'd0, 1, 1, 0, 20, 16'hffff, "R10 R4 wrap");
    run_op(6'h07, 5'd5, 5'd6, 5'd7, 1, 0, 0, 4, 16'h0000, "R3 all off");
    run_op(6'h08, 5'd0, 5'd16, 5'd24, 0, 1, 1, 16, 16'h8001, "R8 edges");
    run_op(6'h09, 5'd10, 5'd11, 5'd12, 1, 1, 1, 16, 16'h6db6, "R8 stall mix");
    summary();
  end

endmodule